// File: doc/BRIEF.md
# Split Accumulator Arithmetic Unit

This block holds the 32-bit accumulator of a small signal-processing core together with the status word that carries its sign and zero flags. The accumulator is kept as two 16-bit registers: the upper half holds bits 31:16 and the lower half holds bits 15:0. Each half can be loaded directly from its own write port, and both halves are always visible on the outputs.

A registered arithmetic unit applies at most one operation per clock to the full 32-bit value. The available operations are add, subtract, compare, AND, OR, XOR, rotate right, rotate left, arithmetic shift right, shift left, increment, decrement, negate and absolute value. A width select chooses between a 16-bit operand and a 32-bit operand. A 16-bit operand is aligned to the upper half, so it acts on bits 31:16. The sign and zero flags always describe the whole 32-bit result. Instruction fetch, operand fetch and the multiplier sit outside this block.

Top module: `split_acc_alu`

## Requirements
- R1: While reset is asserted, and once it is released, both accumulator halves and the whole status word read as zero until something is written.
- R2: `hi_wr_en` loads `hi_wr_data` into bits 31:16 on the next clock and `lo_wr_en` loads `lo_wr_data` into bits 15:0 on the next clock. A write to one half leaves the other half unchanged.
- R3: Opcodes are add=0, sub=1, cmp=2, and=3, or=4, xor=5. For these, when `alu_wide` is 0 the operand is `alu_operand[15:0]` shifted left by 16 bits. When `alu_wide` is 1 the full 32-bit `alu_operand` is used without shifting.
- R4: Compare (opcode 2) computes the accumulator minus the operand and updates the flags, but leaves both halves of the accumulator unchanged.
- R5: After any opcode from 0 to 13, the status register's N flag (bit 15) equals bit 31 of the 32-bit result and its Z flag (bit 13) is 1 exactly when the 32-bit result is zero.
- R6: Opcode 6 rotates right with bit 0 moving into bit 31. Opcode 7 rotates left with bit 31 moving into bit 0. Opcode 8 shifts right and keeps the sign bit. Opcode 9 shifts left and fills bit 0 with zero.
- R7: Increment (10) and decrement (11) wrap modulo 2^32. Negate (12) gives the two's-complement negation. Absolute value (13) negates the value only when bit 31 is set.
- R8: While `alu_valid` is low, the accumulator and the flags keep their values whatever the opcode and operand inputs are.
- R9: `st_wr_en` loads the status register from `st_wr_data`. Bit 7 is the interrupt-enable bit, and it always reads back as zero on `status_rd`.
- R10: If a half write and an ALU operation happen in the same cycle, the written half takes the write data and the other half takes the ALU result. If a status write and a flag update happen in the same cycle, bits 15 and 13 take the flag values and all other bits take the write data.
- R11: Opcodes 14 and 15 change neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_valid | input | 1 | Apply `alu_op` in this cycle |
| alu_op | input | 4 | Operation code |
| alu_wide | input | 1 | 1: use the full 32-bit operand; 0: use a 16-bit operand aligned to the upper half |
| alu_operand | input | 32 | Operand value |
| hi_wr_en | input | 1 | Load the upper half |
| hi_wr_data | input | 16 | Upper-half write data |
| lo_wr_en | input | 1 | Load the lower half |
| lo_wr_data | input | 16 | Lower-half write data |
| st_wr_en | input | 1 | Load the status register |
| st_wr_data | input | 16 | Status write data |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| status_rd | output | 16 | Status read value, with bit 7 forced to zero |

## Verification
The ALU result and a direct write to one accumulator half can land in the same cycle. The bench provokes this by issuing an add while loading the upper half, and checks that the written half takes the write data while the lower half takes the sum. A status write combined with an operation exercises the second collision, where the flag bits must win. Each result is predicted by an independent model and compared through a scoreboard queue one cycle after it is issued.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_ROR = 4'd6,
    OP_ROL = 4'd7,
    OP_SHR = 4'd8,
    OP_SHL = 4'd9,
    OP_INC = 4'd10,
    OP_DEC = 4'd11,
    OP_NEG = 4'd12,
    OP_ABS = 4'd13,
    OP_RS0 = 4'd14,
    OP_RS1 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/acc_operand_align.sv
module acc_operand_align #(
  parameter int HALF_W = 16,
  localparam int ACC_W = 2 * HALF_W
) (
  input  logic             wide,
  input  logic [ACC_W-1:0] operand,
  output logic [ACC_W-1:0] aligned
);
  // A narrow operand acts on the upper half of the accumulator.
  always_comb begin
    if (wide) aligned = operand;
    else      aligned = {operand[HALF_W-1:0], {HALF_W{1'b0}}};
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] opd,
  input  logic [OP_W-1:0]  op,
  output logic [ACC_W-1:0] result,
  output logic             acc_we,
  output logic             flag_we
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  always_comb begin
    result  = acc;
    acc_we  = 1'b1;
    flag_we = 1'b1;
    unique case (op_e)
      OP_ADD: result = acc + opd;
      OP_SUB: result = acc - opd;
      OP_CMP: begin
        result = acc - opd;
        acc_we = 1'b0;
      end
      OP_AND: result = acc & opd;
      OP_OR:  result = acc | opd;
      OP_XOR: result = acc ^ opd;
      OP_ROR: result = {acc[0], acc[ACC_W-1:1]};
      OP_ROL: result = {acc[ACC_W-2:0], acc[ACC_W-1]};
      OP_SHR: result = {acc[ACC_W-1], acc[ACC_W-1:1]};
      OP_SHL: result = {acc[ACC_W-2:0], 1'b0};
      OP_INC: result = acc + 1'b1;
      OP_DEC: result = acc - 1'b1;
      OP_NEG: result = ~acc + 1'b1;
      OP_ABS: result = acc[ACC_W-1] ? (~acc + 1'b1) : acc;
      default: begin
        acc_we  = 1'b0;
        flag_we = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/split_acc_alu.sv
module split_acc_alu
  import acc_alu_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ST_W   = 16,
  parameter int N_BIT  = 15,
  parameter int Z_BIT  = 13,
  parameter int IE_BIT = 7,
  localparam int ACC_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid,
  input  logic [OP_W-1:0]   alu_op,
  input  logic              alu_wide,
  input  logic [ACC_W-1:0]  alu_operand,
  input  logic              hi_wr_en,
  input  logic [HALF_W-1:0] hi_wr_data,
  input  logic              lo_wr_en,
  input  logic [HALF_W-1:0] lo_wr_data,
  input  logic              st_wr_en,
  input  logic [ST_W-1:0]   st_wr_data,
  output logic [HALF_W-1:0] acc_hi,
  output logic [HALF_W-1:0] acc_lo,
  output logic [ST_W-1:0]   status_rd
);
  localparam logic [ST_W-1:0] IE_MASK = ST_W'(1) << IE_BIT;

  logic              rst_sync_n;
  logic [ACC_W-1:0]  acc_q, acc_nx, opd_al, alu_res;
  logic [ST_W-1:0]   st_q, st_nx;
  logic              alu_acc_we, alu_flag_we;
  logic              acc_en, st_en;

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  acc_operand_align #(.HALF_W(HALF_W)) u_align (
    .wide(alu_wide), .operand(alu_operand), .aligned(opd_al)
  );

  acc_alu_core #(.ACC_W(ACC_W)) u_core (
    .acc(acc_q), .opd(opd_al), .op(alu_op),
    .result(alu_res), .acc_we(alu_acc_we), .flag_we(alu_flag_we)
  );

  // Next state: direct half writes override the ALU result per half.
  always_comb begin
    acc_nx = acc_q;
    if (alu_valid && alu_acc_we) acc_nx = alu_res;
    if (hi_wr_en) acc_nx[ACC_W-1:HALF_W] = hi_wr_data;
    if (lo_wr_en) acc_nx[HALF_W-1:0]     = lo_wr_data;
    acc_en = (alu_valid && alu_acc_we) || hi_wr_en || lo_wr_en;
  end

  // Flags override the matching bits of a simultaneous status write.
  always_comb begin
    st_nx = st_wr_en ? st_wr_data : st_q;
    if (alu_valid && alu_flag_we) begin
      st_nx[N_BIT] = alu_res[ACC_W-1];
      st_nx[Z_BIT] = (alu_res == '0);
    end
    st_en = st_wr_en || (alu_valid && alu_flag_we);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  acc_q <= '0;
    else if (acc_en)  acc_q <= acc_nx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  st_q <= '0;
    else if (st_en)   st_q <= st_nx;
  end

  assign acc_hi    = acc_q[ACC_W-1:HALF_W];
  assign acc_lo    = acc_q[HALF_W-1:0];
  assign status_rd = st_q & ~IE_MASK;

  // R4: compare leaves the accumulator alone
  a_r4_cmp_holds_acc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_valid && alu_op == OP_CMP && !hi_wr_en && !lo_wr_en) |=> $stable(acc_q));

  // R8: no valid, no writes -> accumulator and status held
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!alu_valid && !hi_wr_en && !lo_wr_en && !st_wr_en) |=> ($stable(acc_q) && $stable(st_q)));

  // R5: flags agree with the stored 32-bit result
  a_r5_flags_match_acc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_valid && alu_flag_we && alu_acc_we && !hi_wr_en && !lo_wr_en)
      |=> (st_q[N_BIT] == acc_q[ACC_W-1] && st_q[Z_BIT] == (acc_q == '0)));

  // R6: rotate right carries bit 0 into the top bit
  a_r6_ror_wraps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_valid && alu_op == OP_ROR && !hi_wr_en && !lo_wr_en)
      |=> (acc_q == {$past(acc_q[0]), $past(acc_q[ACC_W-1:1])}));

  // R11: reserved codes change nothing
  a_r11_reserved_noop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_valid && alu_op >= 4'd14 && !hi_wr_en && !lo_wr_en && !st_wr_en)
      |=> ($stable(acc_q) && $stable(st_q)));
endmodule

// File: tb/split_acc_alu_tb.sv
module split_acc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alu_valid, alu_wide, hi_wr_en, lo_wr_en, st_wr_en;
  logic [3:0]  alu_op;
  logic [31:0] alu_operand;
  logic [15:0] hi_wr_data, lo_wr_data, st_wr_data;
  logic [15:0] acc_hi, acc_lo, status_rd;

  split_acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
    .alu_wide(alu_wide), .alu_operand(alu_operand),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .status_rd(status_rd)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    logic [31:0] acc;
    logic [15:0] st;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          cyc = 0;
  int          checks = 0;
  int          failures = 0;
  logic [31:0] m_acc;
  logic [15:0] m_st;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare the oldest expected item once it is due.
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if ({acc_hi, acc_lo} !== it.acc || status_rd !== it.st) begin
        failures++;
        $display("FAIL %s acc=%h st=%h expected acc=%h st=%h",
                 it.req, {acc_hi, acc_lo}, status_rd, it.acc, it.st);
      end
    end
  end

  // Reference model from the requirements
  task automatic step(input logic v, input logic [3:0] op, input logic w,
                      input logic [31:0] opnd,
                      input logic hwe, input logic [15:0] hd,
                      input logic lwe, input logic [15:0] ld,
                      input logic swe, input logic [15:0] sd,
                      input string req);
    logic [31:0] o, r;
    logic        aw, fw;
    exp_t        it;
    @(negedge clk);
    alu_valid = v; alu_op = op; alu_wide = w; alu_operand = opnd;
    hi_wr_en = hwe; hi_wr_data = hd; lo_wr_en = lwe; lo_wr_data = ld;
    st_wr_en = swe; st_wr_data = sd;
    o  = w ? opnd : {opnd[15:0], 16'h0};
    aw = 1'b1; fw = 1'b1; r = m_acc;
    case (op)
      4'd0:  r = m_acc + o;
      4'd1:  r = m_acc - o;
      4'd2:  begin r = m_acc - o; aw = 1'b0; end
      4'd3:  r = m_acc & o;
      4'd4:  r = m_acc | o;
      4'd5:  r = m_acc ^ o;
      4'd6:  r = {m_acc[0], m_acc[31:1]};
      4'd7:  r = {m_acc[30:0], m_acc[31]};
      4'd8:  r = $unsigned($signed(m_acc) >>> 1);
      4'd9:  r = m_acc << 1;
      4'd10: r = m_acc + 32'd1;
      4'd11: r = m_acc - 32'd1;
      4'd12: r = 32'd0 - m_acc;
      4'd13: r = m_acc[31] ? 32'd0 - m_acc : m_acc;
      default: begin aw = 1'b0; fw = 1'b0; end
    endcase
    if (swe) m_st = sd;
    if (v && fw) begin m_st[15] = r[31]; m_st[13] = (r == 32'd0); end
    if (v && aw) m_acc = r;
    if (hwe) m_acc[31:16] = hd;
    if (lwe) m_acc[15:0] = ld;
    it.due = cyc + 1; it.acc = m_acc; it.st = m_st & 16'hFF7F; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic op_only(input logic [3:0] op, input logic w,
                         input logic [31:0] opnd, input string req);
    step(1'b1, op, w, opnd, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, req);
  endtask

  task automatic load(input logic [31:0] v, input string req);
    step(1'b0, 4'd0, 1'b0, 32'h0, 1'b1, v[31:16], 1'b1, v[15:0], 1'b0, 16'h0, req);
  endtask

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    alu_valid = 0; alu_op = 0; alu_wide = 0; alu_operand = 0;
    hi_wr_en = 0; hi_wr_data = 0; lo_wr_en = 0; lo_wr_data = 0;
    st_wr_en = 0; st_wr_data = 0;
    m_acc = 0; m_st = 0;
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if ({acc_hi, acc_lo, status_rd} !== 48'h0) begin
      failures++;
      $display("FAIL R1 in reset acc=%h st=%h expected 0", {acc_hi, acc_lo}, status_rd);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;  // R1 after release
    if ({acc_hi, acc_lo, status_rd} !== 48'h0) begin
      failures++;
      $display("FAIL R1 after release acc=%h st=%h expected 0", {acc_hi, acc_lo}, status_rd);
    end

    load(32'h1234_5678, "R2 both halves");
    step(1'b0, 4'd0, 1'b0, 0, 1'b0, 16'h0, 1'b1, 16'hBEEF, 1'b0, 16'h0, "R2 low only");
    step(1'b0, 4'd0, 1'b0, 0, 1'b1, 16'hCAFE, 1'b0, 16'h0, 1'b0, 16'h0, "R2 high only");
    load(32'h0000_0005, "R2 load");
    op_only(4'd0, 1'b0, 32'hFFFF_0001, "R3 add narrow");
    op_only(4'd0, 1'b1, 32'h0000_0001, "R3 add wide");
    op_only(4'd1, 1'b1, 32'h0001_0006, "R5 sub to zero Z");
    load(32'h0003_0000, "R2 load");
    op_only(4'd2, 1'b0, 32'h0000_0003, "R4 cmp equal");
    op_only(4'd2, 1'b0, 32'h0000_0004, "R4 cmp less N");
    op_only(4'd1, 1'b0, 32'h0000_0004, "R5 sub negative");
    load(32'hF0F0_AAAA, "R2 load");
    op_only(4'd3, 1'b0, 32'h0000_FF00, "R3 and narrow");
    op_only(4'd4, 1'b1, 32'h0000_0055, "R3 or wide");
    op_only(4'd5, 1'b0, 32'h1234_FFFF, "R3 xor narrow");
    load(32'h8000_0001, "R2 load");
    op_only(4'd6, 1'b0, 0, "R6 ror");
    op_only(4'd7, 1'b0, 0, "R6 rol");
    op_only(4'd7, 1'b0, 0, "R6 rol msb");
    op_only(4'd8, 1'b0, 0, "R6 shr");
    load(32'h8000_0000, "R2 load");
    op_only(4'd8, 1'b0, 0, "R6 shr sign");
    op_only(4'd9, 1'b0, 0, "R6 shl");
    load(32'hFFFF_FFFF, "R2 load");
    op_only(4'd10, 1'b0, 0, "R7 inc wrap");
    op_only(4'd11, 1'b0, 0, "R7 dec wrap");
    op_only(4'd12, 1'b0, 0, "R7 neg");
    op_only(4'd13, 1'b0, 0, "R7 abs positive");
    op_only(4'd12, 1'b0, 0, "R7 neg");
    op_only(4'd13, 1'b0, 0, "R7 abs negative");
    load(32'h8000_0000, "R2 load");
    op_only(4'd13, 1'b0, 0, "R7 abs min");
    step(1'b0, 4'd1, 1'b1, 32'h1234_5678, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R8 valid low");
    step(1'b0, 4'd12, 1'b0, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R8 valid low neg");
    step(1'b0, 4'd0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 16'hFFFF, "R9 status write ie masked");
    step(1'b0, 4'd0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 16'h0080, "R9 ie only");
    load(32'h0001_0010, "R2 load");
    step(1'b1, 4'd0, 1'b1, 32'h0000_0020, 1'b1, 16'hABCD, 1'b0, 0, 1'b0, 0, "R10 add with high write");
    step(1'b1, 4'd1, 1'b1, 32'h0000_0030, 1'b0, 0, 1'b1, 16'h7777, 1'b0, 0, "R10 sub with low write");
    load(32'h0000_0001, "R2 load");
    step(1'b1, 4'd11, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 16'h80A5, "R10 status write with flags");
    step(1'b1, 4'd14, 1'b1, 32'h5555_5555, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R11 reserved 14");
    step(1'b1, 4'd15, 1'b0, 32'h5555_5555, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R11 reserved 15");
    step(1'b0, 4'd0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R8 idle");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard not drained size=%0d expected 0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule